// File: doc/BRIEF.md
# Descriptor-Driven Memory-to-Stream Packetizer

This block turns a queue of transmit descriptors into outgoing stream packets. A descriptor holds a 32-bit control word, the byte address of a buffer and five application words. The control word gives the buffer length and two framing flags. One flag opens a packet and the other closes it, so a packet can span one descriptor or several. For each accepted descriptor the block reads the buffer through a word-wide memory read port with a fixed latency. It sends the words as beats on a byte-enabled data stream. The final beat of a closing buffer carries the last marker.

When a descriptor opens a packet, the block first sends its application words on a separate control stream. Only after that does the packet's data begin. Descriptors that break the framing rules are dropped, and a sticky error flag is raised.

The block runs as one state machine. In `S_IDLE` it accepts a descriptor. In `S_CTRL` it sends the application words. In `S_READ` it issues one memory read. In `S_WAIT` it waits out the read latency. In `S_BEAT` it presents one data beat. The transitions are:
- `S_IDLE`→`S_CTRL` on a valid opening descriptor.
- `S_IDLE`→`S_READ` on any other valid descriptor.
- `S_CTRL`→`S_READ` after the last application word is accepted.
- `S_READ`→`S_WAIT` always.
- `S_WAIT`→`S_BEAT` when the latency expires.
- `S_BEAT`→`S_READ` on an accepted beat that is not the final beat of the buffer.
- `S_BEAT`→`S_IDLE` on an accepted final beat.
- A descriptor that breaks the framing rules keeps the machine in `S_IDLE`.

Top module: `mm2s_packetizer`

## Requirements
- R1: The buffer length in bytes is control word bits [LEN_W-1:0]. Control bits LEN_W through 25 and the reserved bits 31:28 have no effect.
- R2: Beat i of a buffer carries the memory word read at the buffer address plus i×(DATA_W/8). The read data is taken MEM_LAT cycles after the cycle in which `mem_rd_en` is high.
- R3: Every beat except the final beat of a buffer has all byte enables set. The final beat sets enables only for the remaining (length mod bytes-per-word, or all if zero) bytes, filled contiguously from lane 0 (bit 0 of `m_keep`).
- R4: `m_last` is high exactly on the final beat of a buffer whose control bit 26 (end-of-frame) is 1.
- R5: For a descriptor with control bit 27 (start-of-frame) set, the five application words go out on the control stream in order, word 0 first (desc_app[31:0]), with `ctl_last` on the fifth. All of this completes before that buffer's first data beat. Descriptors without bit 27 produce no control words.
- R6: A descriptor with both bit 26 and bit 27 set is accepted as a complete one-buffer packet.
- R7: A descriptor whose length (per R1) is zero is discarded and raises `frame_err`.
- R8: A descriptor with bit 27 set that arrives while a packet is open is discarded and raises `frame_err`. The open packet continues.
- R9: A descriptor without bit 27 that arrives while no packet is open is discarded and raises `frame_err`.
- R10: `frame_err` stays high once raised until reset, and later valid descriptors are still processed.
- R11: While `m_ready` or `ctl_ready` is low, the respective output holds its beat unchanged. No beat is dropped or duplicated.
- R12: After reset, `desc_ready` is high and `m_valid`, `ctl_valid`, `mem_rd_en` and `frame_err` are low.
- R13: `desc_ready` is high only while no transfer is in progress on either output stream or the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_ctrl | input | 32 | Control word: length, flags, reserved |
| desc_addr | input | ADDR_W | Byte address of the word-aligned buffer |
| desc_app | input | 32×APP_WORDS | Application words, word 0 in the low bits |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | DATA_W | Read data, MEM_LAT cycles after the request |
| m_valid | output | 1 | Data beat valid |
| m_ready | input | 1 | Data beat accepted |
| m_data | output | DATA_W | Data beat payload |
| m_keep | output | DATA_W/8 | Byte enables |
| m_last | output | 1 | Last beat of packet |
| ctl_valid | output | 1 | Control word valid |
| ctl_ready | input | 1 | Control word accepted |
| ctl_data | output | 32 | Application word |
| ctl_last | output | 1 | Last application word |
| frame_err | output | 1 | Sticky framing error |

## Verification
The hardest case to reach is a start-of-frame descriptor arriving while a multi-buffer packet is open. The block must drop it while leaving the open packet intact, so that the packet's later buffers and its last marker come out as if the intruder never existed. The stimulus opens a packet, offers a second opening descriptor, and then closes the packet. The scoreboard holds only the beats of the legitimate buffers, so any leaked data or control words show up as unexpected items. A second hard case is the boundary between the control stream and the data stream under random backpressure on both readies. Each expected beat records how many control words must already have been seen, which catches data that overtakes its control words.

// File: rtl/mm2s_pkg.sv
package mm2s_pkg;
    localparam int CW_W    = 32;
    localparam int EOF_POS = 26;
    localparam int SOF_POS = 27;
    localparam int LEN_MAX = 26;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_READ,
        S_WAIT,
        S_BEAT
    } mm2s_state_t;
endpackage

// File: rtl/mm2s_desc_check.sv
module mm2s_desc_check
    import mm2s_pkg::*;
#(
    parameter int LEN_W = 26
) (
    input  logic [CW_W-1:0]  ctrl,
    input  logic             pkt_open,
    output logic [LEN_W-1:0] len,
    output logic             sof,
    output logic             eof,
    output logic             bad
);
    logic unused_ctrl;

    assign len = ctrl[LEN_W-1:0];
    assign sof = ctrl[SOF_POS];
    assign eof = ctrl[EOF_POS];
    assign unused_ctrl = ^ctrl;

    // zero length, opening inside a packet, continuing outside a packet
    assign bad = (len == '0) || (sof && pkt_open) || (!sof && !pkt_open);
endmodule

// File: rtl/mm2s_keep_gen.sv
module mm2s_keep_gen #(
    parameter int BYTES = 4,
    parameter int LEN_W = 26
) (
    input  logic [LEN_W-1:0] rem,
    output logic [BYTES-1:0] keep,
    output logic             final_beat
);
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(BYTES);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        localparam logic [LEN_W-1:0] LANE = LEN_W'(g);
        assign keep[g] = (rem > LANE);
    end

    assign final_beat = (rem <= WORD_BYTES);
endmodule

// File: rtl/mm2s_lat_timer.sv
module mm2s_lat_timer #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

    logic [CNT_W-1:0] cnt;
    logic             busy;

    assign done = busy && (cnt == LAT_C);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= CNT_W'(1);
            busy <= 1'b1;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mm2s_packetizer.sv
module mm2s_packetizer
    import mm2s_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 26,
    parameter int MEM_LAT   = 2,
    parameter int APP_WORDS = 5,
    parameter bit CTRL_EN   = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    desc_valid,
    output logic                    desc_ready,
    input  logic [31:0]             desc_ctrl,
    input  logic [ADDR_W-1:0]       desc_addr,
    input  logic [32*APP_WORDS-1:0] desc_app,
    output logic                    mem_rd_en,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic [DATA_W-1:0]       mem_rd_data,
    output logic                    m_valid,
    input  logic                    m_ready,
    output logic [DATA_W-1:0]       m_data,
    output logic [DATA_W/8-1:0]     m_keep,
    output logic                    m_last,
    output logic                    ctl_valid,
    input  logic                    ctl_ready,
    output logic [31:0]             ctl_data,
    output logic                    ctl_last,
    output logic                    frame_err
);
    localparam int BYTES = DATA_W / 8;
    localparam int IDX_W = (APP_WORDS > 1) ? $clog2(APP_WORDS) : 1;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(APP_WORDS - 1);
    localparam logic [LEN_W-1:0]  STEP_LEN = LEN_W'(BYTES);
    localparam logic [ADDR_W-1:0] STEP_ADR = ADDR_W'(BYTES);

    mm2s_state_t state, state_nxt;

    logic [LEN_W-1:0]  len_rem;
    logic [ADDR_W-1:0] addr_q;
    logic              eof_q;
    logic              pkt_open;
    logic              err_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       app_q [APP_WORDS];
    logic [DATA_W-1:0] data_q;

    logic [LEN_W-1:0]  d_len;
    logic              d_sof, d_eof, d_bad;
    logic [BYTES-1:0]  keep_w;
    logic              final_w;
    logic              lat_done;
    logic              accept;

    mm2s_desc_check #(.LEN_W(LEN_W)) u_check (
        .ctrl     (desc_ctrl),
        .pkt_open (pkt_open),
        .len      (d_len),
        .sof      (d_sof),
        .eof      (d_eof),
        .bad      (d_bad)
    );

    mm2s_keep_gen #(.BYTES(BYTES), .LEN_W(LEN_W)) u_keep (
        .rem        (len_rem),
        .keep       (keep_w),
        .final_beat (final_w)
    );

    mm2s_lat_timer #(.LAT(MEM_LAT)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == S_READ),
        .done  (lat_done)
    );

    assign accept = desc_valid && desc_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (desc_valid && !d_bad)
                        state_nxt = (CTRL_EN && d_sof) ? S_CTRL : S_READ;
            S_CTRL: if (ctl_ready && idx_q == LAST_IDX)
                        state_nxt = S_READ;
            S_READ: state_nxt = S_WAIT;
            S_WAIT: if (lat_done)
                        state_nxt = S_BEAT;
            S_BEAT: if (m_ready)
                        state_nxt = final_w ? S_IDLE : S_READ;
            default: state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        desc_ready  = (state == S_IDLE);
        ctl_valid   = (state == S_CTRL);
        ctl_data    = app_q[idx_q];
        ctl_last    = (idx_q == LAST_IDX);
        mem_rd_en   = (state == S_READ);
        mem_rd_addr = addr_q;
        m_valid     = (state == S_BEAT);
        m_data      = data_q;
        m_keep      = keep_w;
        m_last      = eof_q && final_w;
        frame_err   = err_q;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_rem  <= '0;
            addr_q   <= '0;
            eof_q    <= 1'b0;
            pkt_open <= 1'b0;
            err_q    <= 1'b0;
            idx_q    <= '0;
            data_q   <= '0;
            for (int k = 0; k < APP_WORDS; k++) app_q[k] <= '0;
        end else begin
            if (accept) begin
                if (d_bad) begin
                    err_q <= 1'b1;
                end else begin
                    len_rem  <= d_len;
                    addr_q   <= desc_addr;
                    eof_q    <= d_eof;
                    pkt_open <= !d_eof;
                    idx_q    <= '0;
                    for (int k = 0; k < APP_WORDS; k++)
                        app_q[k] <= desc_app[k*32 +: 32];
                end
            end
            if (state == S_CTRL && ctl_ready && idx_q != LAST_IDX)
                idx_q <= idx_q + IDX_W'(1);
            if (state == S_WAIT && lat_done)
                data_q <= mem_rd_data;
            if (state == S_BEAT && m_ready && !final_w) begin
                len_rem <= len_rem - STEP_LEN;
                addr_q  <= addr_q + STEP_ADR;
            end
        end
    end
endmodule

// File: rtl/mm2s_packetizer_chk.sv
module mm2s_packetizer_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                desc_ready,
    input logic                mem_rd_en,
    input logic                m_valid,
    input logic                m_ready,
    input logic [DATA_W-1:0]   m_data,
    input logic [DATA_W/8-1:0] m_keep,
    input logic                m_last,
    input logic                ctl_valid,
    input logic                ctl_ready,
    input logic [31:0]         ctl_data,
    input logic                ctl_last,
    input logic                frame_err
);
    localparam int BYTES = DATA_W / 8;

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last));

    assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_data) && $stable(ctl_last));

    assert_keep_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> m_keep[0] && ((m_keep & (m_keep + BYTES'(1))) == '0));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    assert_ctl_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |-> !m_valid);

    assert_idle_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !m_valid && !ctl_valid && !mem_rd_en);
endmodule

bind mm2s_packetizer mm2s_packetizer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_ready (desc_ready),
    .mem_rd_en  (mem_rd_en),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_data     (m_data),
    .m_keep     (m_keep),
    .m_last     (m_last),
    .ctl_valid  (ctl_valid),
    .ctl_ready  (ctl_ready),
    .ctl_data   (ctl_data),
    .ctl_last   (ctl_last),
    .frame_err  (frame_err)
);

// File: tb/mm2s_packetizer_tb.sv
module mm2s_packetizer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int LAT    = 3;
    localparam int APPS   = 5;
    localparam int BYTES  = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_valid = 1'b0;
    logic desc_ready;
    logic [31:0] desc_ctrl = '0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [32*APPS-1:0] desc_app = '0;
    logic mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;
    logic m_valid, m_last, ctl_valid, ctl_last, frame_err;
    logic m_ready = 1'b1, ctl_ready = 1'b1;
    logic [DATA_W-1:0] m_data;
    logic [BYTES-1:0] m_keep;
    logic [31:0] ctl_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm2s_packetizer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                      .MEM_LAT(LAT), .APP_WORDS(APPS), .CTRL_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_ctrl(desc_ctrl), .desc_addr(desc_addr), .desc_app(desc_app),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep),
        .m_last(m_last), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
        .ctl_data(ctl_data), .ctl_last(ctl_last), .frame_err(frame_err));

    // memory model: fixed latency, content derived from the address
    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    logic [ADDR_W-1:0] pipe [LAT];
    always @(posedge clk) begin
        pipe[0] <= mem_rd_addr;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mem_rd_data = mem_word(pipe[LAT-1]);

    // backpressure
    logic [7:0] lfsr = 8'hA7;
    bit bp_mode = 1'b0;
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_ready   <= bp_mode ? lfsr[0] : 1'b1;
        ctl_ready <= bp_mode ? lfsr[2] : 1'b1;
    end

    typedef struct {
        logic [DATA_W-1:0] data;
        logic [BYTES-1:0]  keep;
        logic              last;
        int                ctl_need;
    } beat_t;
    typedef struct {
        logic [31:0] data;
        logic        last;
    } ctlw_t;

    beat_t exp_beats[$];
    ctlw_t exp_ctl[$];
    int ctl_pushed = 0;
    int ctl_seen = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && ctl_valid && ctl_ready) begin
            if (exp_ctl.size() == 0) begin
                check(1'b0, "R5", "unexpected control word", {32'h0, ctl_data}, 64'h0);
            end else begin
                ctlw_t e;
                e = exp_ctl.pop_front();
                check(ctl_data == e.data && ctl_last == e.last, "R5", "control word",
                      {31'h0, ctl_last, ctl_data}, {31'h0, e.last, e.data});
            end
            ctl_seen++;
        end
        if (rst_n && m_valid && m_ready) begin
            if (exp_beats.size() == 0) begin
                check(1'b0, "R11", "unexpected data beat", {32'h0, m_data}, 64'h0);
            end else begin
                beat_t b;
                b = exp_beats.pop_front();
                check(m_data == b.data, "R2", "beat data", {32'h0, m_data}, {32'h0, b.data});
                check(m_keep == b.keep, "R3", "beat keep", {60'h0, m_keep}, {60'h0, b.keep});
                check(m_last == b.last, "R4", "beat last", {63'h0, m_last}, {63'h0, b.last});
                check(ctl_seen >= b.ctl_need, "R5", "control words before data",
                      64'(ctl_seen), 64'(b.ctl_need));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        desc_valid = 1'b0;
        exp_beats.delete();
        exp_ctl.delete();
        ctl_pushed = 0;
        ctl_seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // driver: offers one descriptor and queues what it must produce
    task automatic send_desc(input logic [31:0] ctrl, input logic [ADDR_W-1:0] addr,
                             input bit expect_drop);
        int len, nb;
        @(negedge clk);
        desc_ctrl = ctrl;
        desc_addr = addr;
        for (int k = 0; k < APPS; k++)
            desc_app[k*32 +: 32] = {ctrl[15:0], addr ^ 16'(k * 16'h1111)};
        if (!expect_drop) begin
            if (ctrl[27]) begin
                for (int k = 0; k < APPS; k++) begin
                    ctlw_t c;
                    c.data = desc_app[k*32 +: 32];
                    c.last = (k == APPS - 1);
                    exp_ctl.push_back(c);
                end
                ctl_pushed += APPS;
            end
            len = int'(ctrl[LEN_W-1:0]);
            nb = (len + BYTES - 1) / BYTES;
            for (int i = 0; i < nb; i++) begin
                beat_t b;
                int rem;
                rem = len - i * BYTES;
                b.data = mem_word(addr + ADDR_W'(i * BYTES));
                b.keep = (rem >= BYTES) ? {BYTES{1'b1}} : BYTES'((1 << rem) - 1);
                b.last = ctrl[26] && (i == nb - 1);
                b.ctl_need = ctl_pushed;
                exp_beats.push_back(b);
            end
        end
        desc_valid = 1'b1;
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_beats.size() != 0 || exp_ctl.size() != 0 || !desc_ready)
            @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_beats.size() == 0 && exp_ctl.size() == 0, "R11", "queues drained",
              64'(exp_beats.size()), 64'h0);
    endtask

    localparam logic [31:0] SOF = 32'h0800_0000;
    localparam logic [31:0] EOF = 32'h0400_0000;

    initial begin
        do_reset();
        // R12 reset state
        check(desc_ready == 1'b1, "R12", "desc_ready", 64'(desc_ready), 64'h1);
        check(!m_valid && !ctl_valid, "R12", "stream valids", {62'h0, m_valid, ctl_valid}, 64'h0);
        check(!mem_rd_en, "R12", "mem_rd_en", 64'(mem_rd_en), 64'h0);
        check(!frame_err, "R12", "frame_err", 64'(frame_err), 64'h0);

        // R6: single descriptor packet, 10 bytes -> keep F,F,3
        send_desc(SOF | EOF | 32'd10, 16'h0100, 1'b0);
        drain();

        // multi-descriptor packets under backpressure (R4, R11)
        bp_mode = 1'b1;
        send_desc(SOF | 32'd8, 16'h0200, 1'b0);
        send_desc(32'd5, 16'h0300, 1'b0);
        send_desc(EOF | 32'd4, 16'h0400, 1'b0);
        send_desc(SOF | EOF | 32'd7, 16'h0500, 1'b0);
        send_desc(SOF | 32'd13, 16'h0600, 1'b0);
        send_desc(EOF | 32'd1, 16'h0700, 1'b0);
        drain();
        bp_mode = 1'b0;

        // R1: reserved bits and bits above LEN_W ignored -> length 6
        send_desc(32'hF000_0000 | SOF | EOF | 32'h0010_0000 | 32'd6, 16'h0800, 1'b0);
        drain();
        check(!frame_err, "R1", "no error on valid traffic", 64'(frame_err), 64'h0);

        // R7: zero length discarded
        do_reset();
        send_desc(SOF | EOF, 16'h0900, 1'b1);
        check(frame_err, "R7", "zero length flags error", 64'(frame_err), 64'h1);
        send_desc(SOF | EOF | 32'd9, 16'h0A00, 1'b0);
        drain();
        check(frame_err, "R10", "error stays set", 64'(frame_err), 64'h1);

        // R1/R7: length masked to zero by LEN_W
        do_reset();
        send_desc(SOF | EOF | 32'h0000_1000, 16'h0B00, 1'b1);
        check(frame_err, "R1", "masked zero length flags error", 64'(frame_err), 64'h1);
        drain();

        // R8: second opening descriptor inside an open packet
        do_reset();
        bp_mode = 1'b1;
        send_desc(SOF | 32'd4, 16'h0C00, 1'b0);
        send_desc(SOF | EOF | 32'd4, 16'h0D00, 1'b1);
        check(frame_err, "R8", "open inside packet flags error", 64'(frame_err), 64'h1);
        send_desc(EOF | 32'd3, 16'h0E00, 1'b0);
        drain();
        bp_mode = 1'b0;

        // R9: continuation with no packet open
        do_reset();
        send_desc(EOF | 32'd4, 16'h0F00, 1'b1);
        check(frame_err, "R9", "orphan descriptor flags error", 64'(frame_err), 64'h1);
        send_desc(32'd4, 16'h1000, 1'b1);
        send_desc(SOF | EOF | 32'd2, 16'h1100, 1'b0);
        drain();
        check(frame_err, "R10", "error still set", 64'(frame_err), 64'h1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule